// File: doc/BRIEF.md
# Packed Decimal Operand Loader

This block takes an 80-bit packed-decimal operand, split into a 64-bit low part and a 16-bit high word. It turns the operand into a 64-bit binary magnitude and a separate sign bit. A later stage can then convert that integer to floating point. The operand holds eighteen decimal digits of four bits each. The sign sits alone in the top bit of the high word.

A one-cycle `start` pulse captures the operand. The block then folds in one digit per clock, most significant first, using `acc = acc*10 + digit`. After eighteen steps it raises `done` for one cycle. The magnitude, the sign and a flag for non-decimal nibbles then hold their values until the next accepted start. While `busy` is high, new start pulses are not taken.

Top module: `bcd_int_loader`

## Requirements
- R1: Digit k of the low part (k = 0..15) is in bits 4k+3:4k, and it carries weight 10^k. Digit 0 in bits 3:0 is the least significant.
- R2: Bits 3:0 of the high word are digit 16 (weight 10^16). Bits 7:4 are digit 17 (weight 10^17), the most significant. At most 18 decimal digits contribute to `mag`.
- R3: Bit 15 of the high word gives the sign. `neg` is 1 when that bit is set and 0 when it is clear. `mag` holds the unsigned digit sum whatever the sign is.
- R4: Bits 14:8 of the high word have no effect on `mag`, `neg` or `bad_digit`.
- R5: A start accepted at a clock edge sets `busy` for exactly 18 cycles. `done` is high in the cycle that follows, and `busy` is low in that cycle.
- R6: `done` is high for one cycle only per conversion.
- R7: After `done`, `mag`, `neg` and `bad_digit` hold their values until the next accepted start.
- R8: A nibble with a value above 9 sets `bad_digit` for that conversion. The nibble still adds its binary value times its weight into `mag`.
- R9: A start that arrives while `busy` is high is ignored. The conversion in progress finishes on time with its own operand.
- R10: After reset, `busy`, `done`, `neg` and `bad_digit` are 0 and `mag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the operand and begin a conversion |
| bcd_lo | input | 64 | Digits 0 to 15 |
| bcd_hi | input | 16 | Digits 16 and 17 in bits 7:0, sign in bit 15 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| mag | output | 64 | Binary magnitude |
| neg | output | 1 | Sign of the result |
| bad_digit | output | 1 | A nibble above 9 was seen |

## Verification
The bench places distinct digits at the two ends of the low part and in the high word, so that a loader with swapped digit order or the wrong weights gives the wrong magnitude. It sets every bit from 14 to 8 of the high word to catch a sign taken from the wrong bit or stray bits that leak into the digits. It feeds nibbles above 9, which a design that clamps them or skips the flag would get wrong. It also sends a second start in the middle of a conversion: a loader that reloads would finish late or return the second operand. The timing checks count exact cycles up to `done`, so an off-by-one digit counter is caught.

// File: rtl/bcd_ld_pkg.sv
package bcd_ld_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ld_state_e;

   function automatic logic nib_over_nine(input logic [3:0] nib);
      return nib > 4'd9;
   endfunction
endpackage

// File: rtl/bcd_ld_digits.sv
module bcd_ld_digits #(
   parameter int DIGITS    = 18,
   parameter int LO_DIGITS = 16,
   parameter int NIB_W     = 4,
   parameter int LO_W      = 64,
   parameter int HI_W      = 16,
   parameter int IDX_W     = 5
) (
   input  logic [LO_W-1:0]  op_lo,
   input  logic [HI_W-1:0]  op_hi,
   input  logic [IDX_W-1:0] idx,
   output logic [NIB_W-1:0] digit
);
   logic [NIB_W-1:0] nib_arr [DIGITS];

   for (genvar g = 0; g < DIGITS; g++) begin : g_nib
      if (g < LO_DIGITS) begin : g_low
         assign nib_arr[g] = op_lo[g*NIB_W +: NIB_W];
      end else begin : g_high
         assign nib_arr[g] = op_hi[(g-LO_DIGITS)*NIB_W +: NIB_W];
      end
   end

   always_comb begin
      digit = '0;
      for (int i = 0; i < DIGITS; i++) begin
         if (idx == IDX_W'(i)) digit = nib_arr[i];
      end
   end
endmodule

// File: rtl/bcd_ld_seq.sv
module bcd_ld_seq
   import bcd_ld_pkg::*;
#(
   parameter int DIGITS = 18,
   parameter int IDX_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             load,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] idx
);
   ld_state_e state_q;

   assign busy = (state_q == ST_RUN);
   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state_q <= ST_RUN;
            idx     <= IDX_W'(DIGITS-1);
         end else if (busy) begin
            if (idx == '0) begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end else begin
               idx <= idx - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bcd_ld_mac.sv
module bcd_ld_mac
   import bcd_ld_pkg::*;
#(
   parameter int OUT_W = 64,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [NIB_W-1:0] digit,
   output logic [OUT_W-1:0] acc,
   output logic             bad
);
   logic [OUT_W-1:0] times_ten;

   assign times_ten = (acc << 3) + (acc << 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         bad <= 1'b0;
      end else if (clear) begin
         acc <= '0;
         bad <= 1'b0;
      end else if (step) begin
         acc <= times_ten + OUT_W'(digit);
         bad <= bad | nib_over_nine(4'(digit));
      end
   end
endmodule

// File: rtl/bcd_int_loader.sv
module bcd_int_loader #(
   parameter int DIGITS    = 18,
   parameter int LO_DIGITS = 16,
   parameter int NIB_W     = 4,
   parameter int LO_W      = 64,
   parameter int HI_W      = 16,
   parameter int SIGN_POS  = 15,
   parameter int OUT_W     = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [63:0]      bcd_lo,
   input  logic [15:0]      bcd_hi,
   output logic             busy,
   output logic             done,
   output logic [63:0]      mag,
   output logic             neg,
   output logic             bad_digit
);
   localparam int IDX_W = $clog2(DIGITS);

   initial begin
      assert (LO_DIGITS * NIB_W == LO_W) else $fatal(1, "low part width mismatch");
      assert ((DIGITS - LO_DIGITS) * NIB_W <= SIGN_POS) else $fatal(1, "high digits overlap sign");
      assert (DIGITS <= 18 && OUT_W >= 60) else $fatal(1, "result width too small");
   end

   logic             load, step;
   logic [IDX_W-1:0] idx;
   logic [NIB_W-1:0] digit;
   logic [LO_W-1:0]  lo_q;
   logic [HI_W-1:0]  hi_q;
   logic             neg_q;
   logic [OUT_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         neg_q <= 1'b0;
      end else if (load) begin
         lo_q  <= bcd_lo;
         hi_q  <= bcd_hi;
         neg_q <= bcd_hi[SIGN_POS];
      end
   end

   bcd_ld_seq #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load),
      .step(step), .busy(busy), .done(done), .idx(idx)
   );

   bcd_ld_digits #(
      .DIGITS(DIGITS), .LO_DIGITS(LO_DIGITS), .NIB_W(NIB_W),
      .LO_W(LO_W), .HI_W(HI_W), .IDX_W(IDX_W)
   ) u_dig (
      .op_lo(lo_q), .op_hi(hi_q), .idx(idx), .digit(digit)
   );

   bcd_ld_mac #(.OUT_W(OUT_W), .NIB_W(NIB_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
      .digit(digit), .acc(acc), .bad(bad_digit)
   );

   assign mag = acc[63:0];
   assign neg = neg_q;
endmodule

// File: rtl/bcd_ld_chk.sv
module bcd_ld_chk #(
   parameter int DIGITS = 18
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [63:0] mag,
   input logic        neg,
   input logic        bad_digit
);
   logic [7:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && run_cnt == 8'(DIGITS)));

   assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(mag) && $stable(neg) && $stable(bad_digit)));

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
endmodule

bind bcd_int_loader bcd_ld_chk #(.DIGITS(DIGITS)) u_bcd_ld_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .mag(mag), .neg(neg), .bad_digit(bad_digit)
);

// File: tb/test_bcd_int_loader.sv
module test_bcd_int_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] bcd_lo = '0;
   logic [15:0] bcd_hi = '0;
   logic        busy, done, neg, bad_digit;
   logic [63:0] mag;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bcd_int_loader i_bcd_int_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .bcd_lo(bcd_lo), .bcd_hi(bcd_hi),
      .busy(busy), .done(done), .mag(mag), .neg(neg), .bad_digit(bad_digit)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_mag(input logic [63:0] lo, input logic [15:0] hi);
      logic [63:0] v = 0;
      logic [63:0] w = 1;
      for (int k = 0; k < 18; k++) begin
         logic [3:0] n = (k < 16) ? lo[k*4 +: 4] : hi[(k-16)*4 +: 4];
         v += 64'(n) * w;
         w *= 10;
      end
      return v;
   endfunction

   function automatic logic ref_bad(input logic [63:0] lo, input logic [15:0] hi);
      logic b = 0;
      for (int k = 0; k < 18; k++) begin
         logic [3:0] n = (k < 16) ? lo[k*4 +: 4] : hi[(k-16)*4 +: 4];
         if (n > 9) b = 1;
      end
      return b;
   endfunction

   // full conversion with cycle-exact checks; optional restart attempt mid-run
   task automatic run_conv(input string req, input logic [63:0] lo, input logic [15:0] hi,
                           input bit poke);
      logic [63:0] em = ref_mag(lo, hi);
      logic        eb = ref_bad(lo, hi);
      @(negedge clk);
      bcd_lo = lo; bcd_hi = hi; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R5 busy after start"}, 64'(busy), 64'd1);
      for (int c = 1; c <= 17; c++) begin
         if (poke && c == 6) begin
            bcd_lo = ~lo; bcd_hi = 16'h0099; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         if (done !== 1'b0 || busy !== 1'b1) begin
            check({req, " R5 early done"}, {62'd0, busy, done}, 64'd2);
         end
      end
      @(negedge clk);
      check({req, " R5 done after 18"}, {62'd0, busy, done}, 64'd1);
      check({req, " R1 R2 magnitude"}, mag, em);
      check({req, " R3 sign"}, 64'(neg), 64'(hi[15]));
      check({req, " R8 bad flag"}, 64'(bad_digit), 64'(eb));
      bcd_lo = 64'h1234; bcd_hi = 16'h8011;
      repeat (3) @(negedge clk);
      check({req, " R6 done single"}, 64'(done), 64'd0);
      check({req, " R7 hold mag"}, mag, em);
      check({req, " R7 hold flags"}, {62'd0, neg, bad_digit}, {62'd0, hi[15], eb});
   endtask

   task automatic t_reset();
      check("R10 reset outputs", {mag[59:0], busy, done, neg, bad_digit}, 64'd0);
   endtask

   task automatic t_low_order();
      run_conv("R1 low digits", 64'h0000_0000_0000_0007, 16'h0000, 0);
      run_conv("R1 top low digit", 64'h3000_0000_0000_0000, 16'h0000, 0);
      run_conv("R1 mixed", 64'h1234_5678_9012_3456, 16'h0000, 0);
   endtask

   task automatic t_high_word();
      run_conv("R2 digit16", 64'h0, 16'h0005, 0);
      run_conv("R2 max", 64'h9999_9999_9999_9999, 16'h0099, 0);
      check("R2 max value", mag, 64'd999999999999999999);
   endtask

   task automatic t_sign();
      run_conv("R3 negative", 64'h0000_0000_0000_0042, 16'h8000, 0);
      check("R3 magnitude unsigned", mag, 64'd42);
      run_conv("R3 positive", 64'h0000_0000_0000_0042, 16'h0000, 0);
   endtask

   task automatic t_ignored_bits();
      run_conv("R4 junk bits", 64'h0000_0000_0000_0815, 16'h7F21, 0);
      check("R4 magnitude", mag, 64'd210000000000000815);
      check("R4 no bad no neg", {62'd0, neg, bad_digit}, 64'd0);
   endtask

   task automatic t_bad_digit();
      run_conv("R8 nibble F", 64'h0000_0000_0000_00F1, 16'h0000, 0);
      check("R8 value 151", mag, 64'd151);
      run_conv("R8 high nibble", 64'h0, 16'h00A0, 0);
      run_conv("R8 cleared", 64'h0000_0000_0000_0001, 16'h0000, 0);
   endtask

   task automatic t_restart();
      run_conv("R9 start while busy", 64'h0000_0000_0055_5555, 16'h0001, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_low_order();
      t_high_word();
      t_sign();
      t_ignored_bits();
      t_bad_digit();
      t_restart();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule